// File: doc/BRIEF.md
# Lockable Cache Configuration and Interrupt Register Block

This block is the 32-bit register slave of a small data-cache controller. It holds the cache on/off switch, the bit that gives half the storage over to plain RAM, and the two page-granular bounds of the window of addresses the cache may serve. It also answers, combinationally and for every access the controller presents, whether that address falls inside the window while the cache is on.

The configuration can be frozen two ways. An external lock input freezes every configuration field. An enabled cache additionally freezes the split bit and both bounds, so the window cannot move under live traffic. Any write that tries to change a frozen field is dropped and latches a violation flag. The flag is managed through a raw status register, a masked status register and an enable bit reached through a set address and a clear address. The interrupt output is a single-cycle pulse. A write to the masked status register acts as end-of-interrupt and re-issues the pulse if an enabled violation is still pending.

The register port is a simple valid/write/offset/data port. Read data is combinational in the cycle the read is presented. Writes take effect at the next clock edge.

Top module: `cache_cfg_regs`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x4000_0000 (enable 0, split 1). The bounds, status and all interrupt registers read zero, and irq_o is low.
- R2: In the control register, bit 31 is the cache enable and bit 30 the split (0 = full cache, 1 = half cache, half RAM). All other bits read zero, and cache_en_o and ram_split_o follow the stored bits.
- R3: While lock_i is high, writes to the control, low-bound and high-bound registers change none of their fields.
- R4: While the cache is enabled, the split bit and both bounds ignore writes. The enable bit itself stays writable, so the cache can be switched off.
- R5: The low bound (0x10) and high bound (0x18) store address bits 31:12 in bits 31:12. Bits 11:0 read zero.
- R6: chk_cacheable_o is high exactly when the cache is enabled and chk_addr_i[31:12] lies between the low and high bound, both bounds included. The low bound's lower bits count as zeros and the high bound's as ones.
- R7: Status (0x08) bit 31 shows tag_init_done_i as sampled at the previous clock edge. Other bits read zero.
- R8: Raw status (0x80) bit 1 is set by a blocked write. That is a write to a bound while lock_i or the enable is high, a control write while lock_i is high, or a control write while enabled whose bit 30 differs from the stored split. Writes to other offsets never set it.
- R9: Writing 1 to raw status bit 1 sets the flag. Writing 0 leaves it unchanged.
- R10: Masked status (0x84) bit 1 reads raw AND enable. Writing 1 to it clears the raw flag whether or not the interrupt is enabled.
- R11: Offsets 0x88 and 0x8C both read the shared interrupt enable in bit 1. Writing 1 to bit 1 of 0x88 sets it, writing 1 to bit 1 of 0x8C clears it, and writing 0 does nothing.
- R12: irq_o pulses high for one cycle in the cycle after the masked status rises. Any write to 0x84 that leaves the masked status high produces another one-cycle pulse in the following cycle. Otherwise irq_o is low.
- R13: Reads of unmapped offsets return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | OFFS_W | Byte offset of the register |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Read data, valid in the read cycle, zero otherwise |
| lock_i | input | 1 | External configuration lock |
| tag_init_done_i | input | 1 | Tag/LRU memory initialisation finished |
| chk_addr_i | input | ADDR_W | Access address to classify |
| chk_cacheable_o | output | 1 | Address is in the window and the cache is on |
| cache_en_o | output | 1 | Stored cache enable |
| ram_split_o | output | 1 | Stored split selection |
| irq_o | output | 1 | Lock-violation interrupt pulse |

## Verification
The bench uses the default build: OFFS_W = 8, ADDR_W = DATA_W = 32 and PAGE_LSB = 12. With an 8-bit offset, all 64 word offsets can be swept, which covers every unmapped hole as well as every mapped register. The 4 KiB page granularity lets the window test walk page by page across both bounds. It probes the first and last byte of each page, including one page below the low bound and one above the high bound. A long pseudo-random run of lock, enable and register writes then covers every pairing of the two protection conditions with every field, and compares each register and the interrupt pulse against an arithmetic model.

// File: rtl/cache_cfg_pkg.sv
package cache_cfg_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_LO,
    SEL_HI,
    SEL_RAW,
    SEL_MSK,
    SEL_ESET,
    SEL_ECLR
  } cfg_sel_e;

  localparam logic [7:0] OFF_CTRL = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_LO   = 8'h10;
  localparam logic [7:0] OFF_HI   = 8'h18;
  localparam logic [7:0] OFF_RAW  = 8'h80;
  localparam logic [7:0] OFF_MSK  = 8'h84;
  localparam logic [7:0] OFF_ESET = 8'h88;
  localparam logic [7:0] OFF_ECLR = 8'h8C;

  localparam int unsigned IRQ_VIOL_BIT = 1;

endpackage

// File: rtl/cache_cfg_dec.sv
module cache_cfg_dec
  import cache_cfg_pkg::*;
#(
  parameter int unsigned OFFS_W = 8
) (
  input  logic [OFFS_W-1:0] addr_i,
  output cfg_sel_e          sel_o
);

  always_comb begin
    sel_o = SEL_NONE;
    case (addr_i)
      OFFS_W'(OFF_CTRL): sel_o = SEL_CTRL;
      OFFS_W'(OFF_STAT): sel_o = SEL_STAT;
      OFFS_W'(OFF_LO):   sel_o = SEL_LO;
      OFFS_W'(OFF_HI):   sel_o = SEL_HI;
      OFFS_W'(OFF_RAW):  sel_o = SEL_RAW;
      OFFS_W'(OFF_MSK):  sel_o = SEL_MSK;
      OFFS_W'(OFF_ESET): sel_o = SEL_ESET;
      OFFS_W'(OFF_ECLR): sel_o = SEL_ECLR;
      default:           sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/cache_cfg_prot.sv
module cache_cfg_prot #(
  parameter int unsigned PAGE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              en_bit_i,
  input  logic              split_bit_i,
  input  logic [PAGE_W-1:0] bound_i,
  output logic              en_o,
  output logic              split_o,
  output logic [PAGE_W-1:0] lo_o,
  output logic [PAGE_W-1:0] hi_o,
  output logic              viol_o
);

  logic              en_q, split_q;
  logic [PAGE_W-1:0] lo_q, hi_q;
  logic              frozen;

  // enable is only lock-protected; split and bounds also freeze while enabled
  assign frozen = lock_i | en_q;

  assign viol_o = (wr_ctrl_i & (lock_i | (en_q & (split_bit_i != split_q))))
                | ((wr_lo_i | wr_hi_i) & frozen);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      split_q <= 1'b1;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (wr_ctrl_i && !lock_i) en_q    <= en_bit_i;
      if (wr_ctrl_i && !frozen) split_q <= split_bit_i;
      if (wr_lo_i && !frozen)   lo_q    <= bound_i;
      if (wr_hi_i && !frozen)   hi_q    <= bound_i;
    end
  end

  assign en_o    = en_q;
  assign split_o = split_q;
  assign lo_o    = lo_q;
  assign hi_o    = hi_q;

endmodule

// File: rtl/cache_cfg_win.sv
module cache_cfg_win #(
  parameter int unsigned PAGE_W = 20
) (
  input  logic              en_i,
  input  logic [PAGE_W-1:0] lo_i,
  input  logic [PAGE_W-1:0] hi_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);

  logic above_lo, below_hi;

  assign above_lo = (page_i >= lo_i);
  assign below_hi = (page_i <= hi_i);
  assign hit_o    = en_i & above_lo & below_hi;

endmodule

// File: rtl/cache_cfg_irq.sv
module cache_cfg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic viol_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic eoi_i,
  input  logic ena_set_i,
  input  logic ena_clr_i,
  output logic raw_o,
  output logic ena_o,
  output logic irq_o
);

  logic raw_q, ena_q, msk_prev_q, eoi_q, msk;

  assign msk = raw_q & ena_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q      <= 1'b0;
      ena_q      <= 1'b0;
      msk_prev_q <= 1'b0;
      eoi_q      <= 1'b0;
    end else begin
      if (sw_clr_i)                raw_q <= 1'b0;
      else if (viol_i || sw_set_i) raw_q <= 1'b1;
      if (ena_set_i)      ena_q <= 1'b1;
      else if (ena_clr_i) ena_q <= 1'b0;
      msk_prev_q <= msk;
      eoi_q      <= eoi_i;
    end
  end

  // pulse on a fresh masked event, or re-pulse after end-of-interrupt
  assign irq_o = msk & (~msk_prev_q | eoi_q);
  assign raw_o = raw_q;
  assign ena_o = ena_q;

endmodule

// File: rtl/cache_cfg_regs.sv
module cache_cfg_regs
  import cache_cfg_pkg::*;
#(
  parameter int unsigned OFFS_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [OFFS_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              lock_i,
  input  logic              tag_init_done_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              chk_cacheable_o,
  output logic              cache_en_o,
  output logic              ram_split_o,
  output logic              irq_o
);

  localparam int unsigned PAGE_W    = ADDR_W - PAGE_LSB;
  localparam int unsigned EN_BIT    = DATA_W - 1;
  localparam int unsigned SPLIT_BIT = DATA_W - 2;
  localparam int unsigned RDY_BIT   = DATA_W - 1;

  cfg_sel_e          sel;
  logic              wr, rd;
  logic              wr_ctrl, wr_lo, wr_hi, wr_raw, wr_msk, wr_eset, wr_eclr;
  logic              en_q, split_q, raw_q, ena_q, viol, ready_q;
  logic [PAGE_W-1:0] lo_q, hi_q;
  logic              vbit;
  logic              unused_bits;

  assign wr   = req_valid_i & req_write_i;
  assign rd   = req_valid_i & ~req_write_i;
  assign vbit = req_wdata_i[IRQ_VIOL_BIT];
  assign unused_bits = ^{req_wdata_i, chk_addr_i};

  cache_cfg_dec #(.OFFS_W(OFFS_W)) dec_i (
    .addr_i (req_addr_i),
    .sel_o  (sel)
  );

  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign wr_lo   = wr && (sel == SEL_LO);
  assign wr_hi   = wr && (sel == SEL_HI);
  assign wr_raw  = wr && (sel == SEL_RAW);
  assign wr_msk  = wr && (sel == SEL_MSK);
  assign wr_eset = wr && (sel == SEL_ESET);
  assign wr_eclr = wr && (sel == SEL_ECLR);

  cache_cfg_prot #(.PAGE_W(PAGE_W)) prot_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (lock_i),
    .wr_ctrl_i   (wr_ctrl),
    .wr_lo_i     (wr_lo),
    .wr_hi_i     (wr_hi),
    .en_bit_i    (req_wdata_i[EN_BIT]),
    .split_bit_i (req_wdata_i[SPLIT_BIT]),
    .bound_i     (req_wdata_i[ADDR_W-1:PAGE_LSB]),
    .en_o        (en_q),
    .split_o     (split_q),
    .lo_o        (lo_q),
    .hi_o        (hi_q),
    .viol_o      (viol)
  );

  cache_cfg_win #(.PAGE_W(PAGE_W)) win_i (
    .en_i   (en_q),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .page_i (chk_addr_i[ADDR_W-1:PAGE_LSB]),
    .hit_o  (chk_cacheable_o)
  );

  cache_cfg_irq irq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .viol_i    (viol),
    .sw_set_i  (wr_raw & vbit),
    .sw_clr_i  (wr_msk & vbit),
    .eoi_i     (wr_msk),
    .ena_set_i (wr_eset & vbit),
    .ena_clr_i (wr_eclr & vbit),
    .raw_o     (raw_q),
    .ena_o     (ena_q),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= tag_init_done_i;
  end

  always_comb begin
    rsp_rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_CTRL: begin
          rsp_rdata_o[EN_BIT]    = en_q;
          rsp_rdata_o[SPLIT_BIT] = split_q;
        end
        SEL_STAT: rsp_rdata_o[RDY_BIT]                 = ready_q;
        SEL_LO:   rsp_rdata_o[ADDR_W-1:PAGE_LSB]       = lo_q;
        SEL_HI:   rsp_rdata_o[ADDR_W-1:PAGE_LSB]       = hi_q;
        SEL_RAW:  rsp_rdata_o[IRQ_VIOL_BIT]            = raw_q;
        SEL_MSK:  rsp_rdata_o[IRQ_VIOL_BIT]            = raw_q & ena_q;
        SEL_ESET,
        SEL_ECLR: rsp_rdata_o[IRQ_VIOL_BIT]            = ena_q;
        default:  rsp_rdata_o = '0;
      endcase
    end
  end

  assign cache_en_o  = en_q;
  assign ram_split_o = split_q;

endmodule

// File: rtl/cache_cfg_regs_chk.sv
module cache_cfg_regs_chk
  import cache_cfg_pkg::*;
#(
  parameter int unsigned OFFS_W   = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic                       req_write_i,
  input logic [OFFS_W-1:0]          req_addr_i,
  input logic                       clr_bit_i,
  input logic                       lock_i,
  input logic                       cache_en_i,
  input logic                       split_i,
  input logic [ADDR_W-PAGE_LSB-1:0] lo_i,
  input logic [ADDR_W-PAGE_LSB-1:0] hi_i,
  input logic                       raw_i,
  input logic                       ena_i,
  input logic                       irq_i,
  input logic                       cacheable_i
);

  logic w, at_ctrl, at_bound, at_msk;
  assign w        = req_valid_i & req_write_i;
  assign at_ctrl  = (req_addr_i == OFFS_W'(OFF_CTRL));
  assign at_bound = (req_addr_i == OFFS_W'(OFF_LO)) || (req_addr_i == OFFS_W'(OFF_HI));
  assign at_msk   = (req_addr_i == OFFS_W'(OFF_MSK));

  p_lock_en_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w && at_ctrl && lock_i |=> $stable(cache_en_i));

  p_split_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w && at_ctrl && (lock_i || cache_en_i) |=> $stable(split_i));

  p_bound_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w && at_bound && (lock_i || cache_en_i) |=> $stable(lo_i) && $stable(hi_i));

  p_viol_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w && at_bound && (lock_i || cache_en_i) |=> raw_i);

  p_msk_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w && at_msk && clr_bit_i |=> !raw_i);

  p_irq_masked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> raw_i && ena_i);

  p_irq_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i && ena_i) |-> irq_i);

  p_cacheable_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cacheable_i |-> cache_en_i);

endmodule

bind cache_cfg_regs cache_cfg_regs_chk #(
  .OFFS_W   (OFFS_W),
  .ADDR_W   (ADDR_W),
  .PAGE_LSB (PAGE_LSB)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .clr_bit_i   (req_wdata_i[1]),
  .lock_i      (lock_i),
  .cache_en_i  (cache_en_o),
  .split_i     (ram_split_o),
  .lo_i        (lo_q),
  .hi_i        (hi_q),
  .raw_i       (raw_q),
  .ena_i       (ena_q),
  .irq_i       (irq_o),
  .cacheable_i (chk_cacheable_o)
);

// File: tb/cache_cfg_regs_tb_top.sv
module cache_cfg_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OFFS_W = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic [OFFS_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic [DATA_W-1:0] rsp_rdata_o;
  logic              lock_i = 1'b0;
  logic              tag_init_done_i = 1'b0;
  logic [ADDR_W-1:0] chk_addr_i = '0;
  logic              chk_cacheable_o, cache_en_o, ram_split_o, irq_o;

  cache_cfg_regs dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_vec = 0;
  int n_bad = 0;

  // reference model
  logic        m_en = 1'b0, m_split = 1'b1, m_raw = 1'b0, m_ena = 1'b0;
  logic [19:0] m_lo = '0, m_hi = '0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(logic [7:0] off);
    case (off)
      8'h04: return {m_en, m_split, 30'd0};
      8'h08: return {tag_init_done_i, 31'd0};
      8'h10: return {m_lo, 12'd0};
      8'h18: return {m_hi, 12'd0};
      8'h80: return {30'd0, m_raw, 1'b0};
      8'h84: return {30'd0, m_raw & m_ena, 1'b0};
      8'h88, 8'h8C: return {30'd0, m_ena, 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] off);
    case (off)
      8'h04: return "R2 ctrl";
      8'h08: return "R7 status";
      8'h10, 8'h18: return "R5 bound";
      8'h80: return "R9 raw";
      8'h84: return "R10 masked";
      8'h88, 8'h8C: return "R11 enable";
      default: return "R13 unmapped";
    endcase
  endfunction

  task automatic check_reg(logic [7:0] off);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = off;
    #1;
    check(tag_of(off), rsp_rdata_o, exp_reg(off));
    check("R12 irq idle", {31'd0, irq_o}, 32'd0);
    req_valid_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] off, logic [31:0] d);
    logic old_msk, viol, eoi, exp_irq;
    old_msk = m_raw & m_ena; viol = 1'b0; eoi = 1'b0;
    case (off)
      8'h04: begin
        viol = lock_i | (m_en & (d[30] != m_split));
        if (!lock_i && !m_en) m_split = d[30];
        if (!lock_i) m_en = d[31];
      end
      8'h10: if (lock_i || m_en) viol = 1'b1; else m_lo = d[31:12];
      8'h18: if (lock_i || m_en) viol = 1'b1; else m_hi = d[31:12];
      8'h80: if (d[1]) m_raw = 1'b1;
      8'h84: begin eoi = 1'b1; if (d[1]) m_raw = 1'b0; end
      8'h88: if (d[1]) m_ena = 1'b1;
      8'h8C: if (d[1]) m_ena = 1'b0;
      default: ;
    endcase
    if (viol) m_raw = 1'b1;
    exp_irq = (m_raw & m_ena) & (~old_msk | eoi);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = off; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
    #1;
    check("R12 irq pulse", {31'd0, irq_o}, {31'd0, exp_irq});
  endtask

  task automatic probe(logic [31:0] a);
    logic exp;
    exp = m_en && (a[31:12] >= m_lo) && (a[31:12] <= m_hi);
    @(negedge clk_i);
    chk_addr_i = a;
    #1;
    check("R6 window", {31'd0, chk_cacheable_o}, {31'd0, exp});
  endtask

  task automatic check_all();
    check_reg(8'h04); check_reg(8'h08); check_reg(8'h10); check_reg(8'h18);
    check_reg(8'h80); check_reg(8'h84); check_reg(8'h88); check_reg(8'h8C);
    check("R2 en pin", {31'd0, cache_en_o}, {31'd0, m_en});
    check("R2 split pin", {31'd0, ram_split_o}, {31'd0, m_split});
    probe({m_lo, 12'h000});
    probe({m_lo, 12'h000} - 32'd1);
    probe({m_hi, 12'hFFF});
    probe({m_hi, 12'hFFF} + 32'd1);
    probe(rnd());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 en", {31'd0, cache_en_o}, 32'd0);
    check("R1 split", {31'd0, ram_split_o}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] o;
      o = (i == 0) ? 8'h04 : (i == 1) ? 8'h08 : (i == 2) ? 8'h10 : (i == 3) ? 8'h18 :
          (i == 4) ? 8'h80 : (i == 5) ? 8'h84 : (i == 6) ? 8'h88 : 8'h8C;
      @(negedge clk_i);
      req_valid_i = 1'b1; req_addr_i = o; #1;
      check("R1 reset read", rsp_rdata_o, (o == 8'h04) ? 32'h4000_0000 : 32'd0);
      req_valid_i = 1'b0;
    end

    // R2 control fields
    wr(8'h04, 32'h3FFF_FFFF);
    check_reg(8'h04);
    wr(8'h04, 32'hFFFF_FFFF);
    check_reg(8'h04);
    check("R2 en set", {31'd0, cache_en_o}, 32'd1);
    wr(8'h04, 32'h4000_0000);
    check_all();

    // R3 lock protection
    lock_i = 1'b1;
    wr(8'h04, 32'h8000_0000);
    check("R3 en held", {31'd0, cache_en_o}, 32'd0);
    wr(8'h10, 32'hABCD_E123);
    wr(8'h18, 32'hFFFF_F000);
    check_all();
    check("R8 viol on lock", {31'd0, m_raw}, 32'd1);
    lock_i = 1'b0;
    wr(8'h84, 32'h2);

    // R4 enable protection
    wr(8'h10, 32'h0010_0000);
    wr(8'h18, 32'h0010_3ABC);
    wr(8'h04, 32'hC000_0000);
    check("R8 no viol same split", {31'd0, m_raw}, 32'd0);
    wr(8'h04, 32'h8000_0000);
    check("R4 split held", {31'd0, ram_split_o}, 32'd1);
    wr(8'h18, 32'h0020_0000);
    check_reg(8'h18);
    check_reg(8'h80);
    wr(8'h04, 32'h4000_0000);
    check("R4 en cleared", {31'd0, cache_en_o}, 32'd0);
    wr(8'h84, 32'h2);

    // R6 window sweep
    wr(8'h04, 32'hC000_0000);
    for (int p = 32'hFE; p <= 32'h105; p++) begin
      probe({p[19:0], 12'h000});
      probe({p[19:0], 12'hFFF});
    end
    wr(8'h04, 32'h4000_0000);
    for (int p = 32'hFF; p <= 32'h104; p++) probe({p[19:0], 12'h800});

    // R7 status
    tag_init_done_i = 1'b1;
    check_reg(8'h08);
    tag_init_done_i = 1'b0;
    check_reg(8'h08);

    // R9..R12 interrupt control
    wr(8'h80, 32'h0);
    check_reg(8'h80);
    wr(8'h88, 32'h2);
    wr(8'h80, 32'h2);
    check_reg(8'h84);
    wr(8'h84, 32'h0);
    wr(8'h84, 32'h0);
    wr(8'h8C, 32'h0);
    check_reg(8'h8C);
    wr(8'h8C, 32'h2);
    check_reg(8'h84);
    check_reg(8'h80);
    wr(8'h84, 32'h2);
    check_reg(8'h80);
    wr(8'h88, 32'hFFFF_FFFD);
    check_reg(8'h88);

    // R13 full offset sweep
    for (int i = 0; i < 64; i++) begin
      logic [7:0] o;
      o = 8'(i * 4);
      check_reg(o);
      if (tag_of(o) == "R13 unmapped") wr(o, 32'hFFFF_FFFF);
    end
    check_all();

    // randomized mix
    for (int s = 0; s < 300; s++) begin
      logic [31:0] r;
      logic [7:0]  o;
      r = rnd();
      @(negedge clk_i);
      lock_i = (r[3:0] == 4'd0);
      tag_init_done_i = r[4];
      case (r[11:8] % 10)
        0, 9: o = 8'h04;
        1: o = 8'h10;
        2: o = 8'h18;
        3: o = 8'h80;
        4: o = 8'h84;
        5: o = 8'h88;
        6: o = 8'h8C;
        7: o = 8'h08;
        default: o = {r[17:12], 2'b00} | 8'h40;
      endcase
      wr(o, rnd());
      check_all();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule